// File: doc/BRIEF.md
# Bidirectional Station Ring

A ring network that links a parameterised number of stations (fourteen by default) with two rings running in opposite directions. Every station owns one register slot on each ring; a packet sitting in a slot moves to the neighbouring station's slot on every clock edge. It moves one way on the clockwise ring and the other way on the counter-clockwise ring. A station leaves a packet on the ring until the packet reaches the station whose number matches its destination field. That station takes the packet off the ring and frees the slot.

Each station has one inject port that uses valid, ready, destination and payload. It has two eject ports, one for each ring. The sender picks the ring that gives the shorter trip, so no packet travels more than half the ring. A packet already on a ring never waits. New traffic waits instead, with ready held low, until its outgoing slot is free. A packet addressed to the station that sends it never enters a ring. It is handed straight to that station's clockwise eject port.

Top module: `ring_noc`

## Requirements
- R1: After reset, every eject valid output is low, and every station's inject ready is high for any destination below the station count.
- R2: For source s and destination d, let the clockwise distance be (d - s) mod N. A non-local packet uses the clockwise ring (station i to i+1 mod N) when that distance is at most N/2, and the counter-clockwise ring (station i to i-1 mod N) otherwise. Ties go clockwise. The ring used is shown by which eject port delivers the packet: `ej_cw_*` for clockwise, `ej_ccw_*` for counter-clockwise.
- R3: A packet accepted on clock edge k, with hop count h, is presented on its destination's eject port for exactly the one cycle that follows edge k+h, whatever else the ring carries.
- R4: No delivery takes more than N/2 hops; with N = 14 the largest latency is 7 cycles.
- R5: A packet whose destination equals its own station takes zero hops. It appears on that station's clockwise eject port in the cycle after the edge that accepts it, and it occupies no ring slot.
- R6: While a packet is passing through station s on one ring, station s holds inject ready low for any packet that would go out on that ring. Traffic for the other ring is unaffected.
- R7: While the clockwise ring is delivering a packet to station s, a local packet at station s sees ready low.
- R8: Every accepted packet is delivered exactly once, at its destination, with its payload unchanged.
- R9: A destination value of N or above is never accepted: ready stays low.
- R10: A station may eject one packet from each ring in the same cycle, on its two eject ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inj_valid | input | N_STATIONS | Per-station inject request |
| inj_ready | output | N_STATIONS | Per-station inject accept (depends on that station's destination) |
| inj_dest | input | N_STATIONS*DST_W | Per-station destination station number |
| inj_data | input | N_STATIONS*DATA_W | Per-station payload |
| ej_cw_valid | output | N_STATIONS | Clockwise-ring (and local) delivery strobe |
| ej_cw_data | output | N_STATIONS*DATA_W | Clockwise-ring (and local) delivered payload |
| ej_ccw_valid | output | N_STATIONS | Counter-clockwise-ring delivery strobe |
| ej_ccw_data | output | N_STATIONS*DATA_W | Counter-clockwise-ring delivered payload |

## Verification
Two things can happen at one station in the same cycle: a packet can arrive there, and a new packet can ask to leave. A passing packet collides with an injection bound for the same ring. A clockwise delivery collides with a local request. The bench sets up each case directly: it injects a packet and then, one cycle later, makes a request at the station the packet has just reached. It expects ready low for the ring that is taken and ready high for the other ring. Constrained-random traffic on all stations then forces many more such collisions. Every delivery is judged against a record of exact latency, ring and destination, and a final tally confirms that each packet arrived exactly once.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int RING_LANES = 2;

  typedef enum logic {
    RING_CW  = 1'b0,
    RING_CCW = 1'b1
  } ring_dir_e;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ring_route.sv
module ring_route
  import ring_pkg::*;
#(
  parameter int N_STATIONS = 14,
  parameter int DST_W      = 4,
  parameter int MY_ID      = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_v,
  input  logic [DST_W-1:0] req_dst,
  input  logic             cw_busy,
  input  logic             ccw_busy,
  input  logic             cw_hit,
  output logic             req_rdy,
  output logic             put_cw,
  output logic             put_ccw,
  output logic             put_local
);
  localparam logic [DST_W:0] N_L    = (DST_W+1)'(N_STATIONS);
  localparam logic [DST_W:0] MY_L   = (DST_W+1)'(MY_ID);
  localparam logic [DST_W:0] HALF_L = (DST_W+1)'(N_STATIONS / 2);

  logic           dst_ok;
  logic           is_local;
  logic [DST_W:0] sum_raw;
  logic [DST_W:0] cw_dist;
  ring_dir_e      dir;

  always_comb begin
    dst_ok   = ({1'b0, req_dst} < N_L);
    is_local = dst_ok && ({1'b0, req_dst} == MY_L);
    sum_raw  = {1'b0, req_dst} + (N_L - MY_L);
    cw_dist  = (sum_raw >= N_L) ? (sum_raw - N_L) : sum_raw;
    dir      = (cw_dist <= HALF_L) ? RING_CW : RING_CCW;

    if (!dst_ok)              req_rdy = 1'b0;
    else if (is_local)        req_rdy = !cw_hit;
    else if (dir == RING_CW)  req_rdy = !cw_busy;
    else                      req_rdy = !ccw_busy;

    put_local = req_v && req_rdy && is_local;
    put_cw    = req_v && req_rdy && !is_local && (dir == RING_CW);
    put_ccw   = req_v && req_rdy && !is_local && (dir == RING_CCW);
  end

  // R2: a packet goes to at most one place
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({put_cw, put_ccw, put_local}));

  // R9: nothing leaves with an out-of-range destination
  p_bad_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (put_cw || put_ccw || put_local) |-> ({1'b0, req_dst} < N_L));
endmodule

// File: rtl/ring_lane_stage.sv
module ring_lane_stage #(
  parameter int DST_W  = 4,
  parameter int DATA_W = 16,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_v,
  input  logic [DST_W-1:0]  up_dst,
  input  logic [DATA_W-1:0] up_pl,
  input  logic              inj_v,
  input  logic [DST_W-1:0]  inj_dst,
  input  logic [DATA_W-1:0] inj_pl,
  input  logic              loc_v,
  input  logic [DATA_W-1:0] loc_pl,
  output logic              out_v,
  output logic [DST_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_pl,
  output logic              busy,
  output logic              hit,
  output logic              ej_v,
  output logic [DATA_W-1:0] ej_pl
);
  logic              slot_v;
  logic [DST_W-1:0]  slot_dst;
  logic [DATA_W-1:0] slot_pl;
  logic              at_home;
  logic              passing;
  logic              ej_v_d;
  logic [DATA_W-1:0] ej_pl_d;

  always_comb begin
    at_home = slot_v && (slot_dst == DST_W'(MY_ID));
    passing = slot_v && !at_home;
    out_v   = passing || inj_v;
    out_dst = passing ? slot_dst : inj_dst;
    out_pl  = passing ? slot_pl  : inj_pl;
    ej_v_d  = at_home || loc_v;
    ej_pl_d = at_home ? slot_pl : loc_pl;
  end

  assign busy = passing;
  assign hit  = at_home;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= 1'b0;
      ej_v   <= 1'b0;
    end else begin
      slot_v <= up_v;
      ej_v   <= ej_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (up_v) begin
      slot_dst <= up_dst;
      slot_pl  <= up_pl;
    end
    if (ej_v_d) ej_pl <= ej_pl_d;
  end

  // R6: an injection never displaces a packet in transit
  p_transit_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_v |-> !passing);

  // R7: a local delivery never coincides with a ring delivery on this lane
  p_home_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_v && at_home));

  // R3: an arrival is presented on the eject port on the next cycle
  p_hit_ejects_r3: assert property (@(posedge clk) disable iff (!rst_n)
    at_home |=> (ej_v && ej_pl == $past(slot_pl)));
endmodule

// File: rtl/ring_noc.sv
module ring_noc #(
  parameter  int N_STATIONS = 14,
  parameter  int DATA_W     = 16,
  localparam int DST_W      = (N_STATIONS > 1) ? $clog2(N_STATIONS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_STATIONS-1:0]        inj_valid,
  output logic [N_STATIONS-1:0]        inj_ready,
  input  logic [N_STATIONS*DST_W-1:0]  inj_dest,
  input  logic [N_STATIONS*DATA_W-1:0] inj_data,
  output logic [N_STATIONS-1:0]        ej_cw_valid,
  output logic [N_STATIONS*DATA_W-1:0] ej_cw_data,
  output logic [N_STATIONS-1:0]        ej_ccw_valid,
  output logic [N_STATIONS*DATA_W-1:0] ej_ccw_data
);
  logic srst_n;

  ring_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  logic              cw_out_v   [N_STATIONS];
  logic [DST_W-1:0]  cw_out_dst [N_STATIONS];
  logic [DATA_W-1:0] cw_out_pl  [N_STATIONS];
  logic              ccw_out_v  [N_STATIONS];
  logic [DST_W-1:0]  ccw_out_dst[N_STATIONS];
  logic [DATA_W-1:0] ccw_out_pl [N_STATIONS];
  logic [N_STATIONS-1:0] cw_busy, ccw_busy, cw_hit, ccw_hit;
  logic [N_STATIONS-1:0] put_cw, put_ccw, put_loc;

  for (genvar s = 0; s < N_STATIONS; s++) begin : g_st
    localparam int UP_CW  = (s + N_STATIONS - 1) % N_STATIONS;
    localparam int UP_CCW = (s + 1) % N_STATIONS;

    ring_route #(
      .N_STATIONS (N_STATIONS),
      .DST_W      (DST_W),
      .MY_ID      (s)
    ) u_route (
      .clk       (clk),
      .rst_n     (srst_n),
      .req_v     (inj_valid[s]),
      .req_dst   (inj_dest[s*DST_W +: DST_W]),
      .cw_busy   (cw_busy[s]),
      .ccw_busy  (ccw_busy[s]),
      .cw_hit    (cw_hit[s]),
      .req_rdy   (inj_ready[s]),
      .put_cw    (put_cw[s]),
      .put_ccw   (put_ccw[s]),
      .put_local (put_loc[s])
    );

    ring_lane_stage #(
      .DST_W  (DST_W),
      .DATA_W (DATA_W),
      .MY_ID  (s)
    ) u_cw (
      .clk     (clk),
      .rst_n   (srst_n),
      .up_v    (cw_out_v[UP_CW]),
      .up_dst  (cw_out_dst[UP_CW]),
      .up_pl   (cw_out_pl[UP_CW]),
      .inj_v   (put_cw[s]),
      .inj_dst (inj_dest[s*DST_W +: DST_W]),
      .inj_pl  (inj_data[s*DATA_W +: DATA_W]),
      .loc_v   (put_loc[s]),
      .loc_pl  (inj_data[s*DATA_W +: DATA_W]),
      .out_v   (cw_out_v[s]),
      .out_dst (cw_out_dst[s]),
      .out_pl  (cw_out_pl[s]),
      .busy    (cw_busy[s]),
      .hit     (cw_hit[s]),
      .ej_v    (ej_cw_valid[s]),
      .ej_pl   (ej_cw_data[s*DATA_W +: DATA_W])
    );

    ring_lane_stage #(
      .DST_W  (DST_W),
      .DATA_W (DATA_W),
      .MY_ID  (s)
    ) u_ccw (
      .clk     (clk),
      .rst_n   (srst_n),
      .up_v    (ccw_out_v[UP_CCW]),
      .up_dst  (ccw_out_dst[UP_CCW]),
      .up_pl   (ccw_out_pl[UP_CCW]),
      .inj_v   (put_ccw[s]),
      .inj_dst (inj_dest[s*DST_W +: DST_W]),
      .inj_pl  (inj_data[s*DATA_W +: DATA_W]),
      .loc_v   (1'b0),
      .loc_pl  ({DATA_W{1'b0}}),
      .out_v   (ccw_out_v[s]),
      .out_dst (ccw_out_dst[s]),
      .out_pl  (ccw_out_pl[s]),
      .busy    (ccw_busy[s]),
      .hit     (ccw_hit[s]),
      .ej_v    (ej_ccw_valid[s]),
      .ej_pl   (ej_ccw_data[s*DATA_W +: DATA_W])
    );

    // R10: a counter-clockwise arrival is delivered regardless of clockwise traffic
    p_ccw_delivers_r10: assert property (@(posedge clk) disable iff (!srst_n)
      ccw_hit[s] |=> ej_ccw_valid[s]);
  end
endmodule

// File: tb/ring_noc_tb_top.sv
module ring_noc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 14;
  localparam int DW = 16;
  localparam int AW = $clog2(N);
  localparam int MAX_ID = 4096;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      inj_valid;
  logic [N-1:0]      inj_ready;
  logic [N*AW-1:0]   inj_dest;
  logic [N*DW-1:0]   inj_data;
  logic [N-1:0]      ej_cw_valid, ej_ccw_valid;
  logic [N*DW-1:0]   ej_cw_data, ej_ccw_data;

  ring_noc #(.N_STATIONS(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_dest(inj_dest), .inj_data(inj_data),
    .ej_cw_valid(ej_cw_valid), .ej_cw_data(ej_cw_data),
    .ej_ccw_valid(ej_ccw_valid), .ej_ccw_data(ej_ccw_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_err    = 0;
  int next_id  = 0;
  int max_lat  = 0;
  int exp_dst [MAX_ID];
  int exp_lane[MAX_ID];
  int exp_hops[MAX_ID];
  int acc_cyc [MAX_ID];
  int seen    [MAX_ID];
  bit acc     [MAX_ID];
  bit stg_v   [N];
  int stg_d   [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Shortest route from the requirements: lane 0 clockwise, 1 counter-clockwise
  function automatic void route(input int src, input int dst, output int lane, output int hops);
    int d = (dst - src + N) % N;
    if (d <= N/2) begin lane = 0; hops = d; end
    else          begin lane = 1; hops = N - d; end
  endfunction

  task automatic observe();
    for (int i = 0; i < N; i++) begin
      for (int ln = 0; ln < 2; ln++) begin
        bit v  = (ln == 0) ? ej_cw_valid[i] : ej_ccw_valid[i];
        int id = (ln == 0) ? int'(ej_cw_data[i*DW +: DW]) : int'(ej_ccw_data[i*DW +: DW]);
        if (v) begin
          if (id >= MAX_ID || !acc[id]) chk(1'b0, "R8 unknown packet id", id, -1);
          else begin
            int lat = cyc - acc_cyc[id];
            chk(seen[id] == 0, "R8 duplicate delivery", seen[id], 0);
            chk(exp_dst[id] == i, "R8 delivered at wrong station", i, exp_dst[id]);
            chk(exp_lane[id] == ln, "R2 ring used", ln, exp_lane[id]);
            chk(lat == exp_hops[id], "R3 latency in cycles", lat, exp_hops[id]);
            if (lat > max_lat) max_lat = lat;
            seen[id]++;
          end
        end
      end
    end
  endtask

  task automatic step();
    int ids[N];
    @(negedge clk);
    observe();
    for (int i = 0; i < N; i++) begin
      inj_valid[i] = stg_v[i];
      inj_dest[i*AW +: AW] = stg_d[i][AW-1:0];
      ids[i] = next_id;
      inj_data[i*DW +: DW] = DW'(next_id);
      if (stg_v[i]) next_id++;
    end
    #1;
    for (int i = 0; i < N; i++) begin
      if (stg_v[i] && inj_ready[i]) begin
        int ln, hp;
        route(i, stg_d[i], ln, hp);
        acc[ids[i]]      = 1'b1;
        exp_dst[ids[i]]  = stg_d[i];
        exp_lane[ids[i]] = ln;
        exp_hops[ids[i]] = hp;
        acc_cyc[ids[i]]  = cyc + 1;
      end
    end
  endtask

  task automatic clear_stage();
    for (int i = 0; i < N; i++) begin stg_v[i] = 1'b0; stg_d[i] = 0; end
  endtask

  task automatic drain(input int n);
    clear_stage();
    repeat (n) step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a17));
    for (int k = 0; k < MAX_ID; k++) begin acc[k] = 0; seen[k] = 0; end
    inj_valid = '0; inj_dest = '0; inj_data = '0;
    clear_stage();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: idle after reset, all stations ready
    @(negedge clk);
    chk(ej_cw_valid == '0 && ej_ccw_valid == '0, "R1 eject idle after reset",
        int'(ej_cw_valid | ej_ccw_valid), 0);
    for (int i = 0; i < N; i++) begin stg_v[i] = 1'b1; stg_d[i] = (i + 3) % N; end
    step();
    chk(inj_ready == '1, "R1 all ready on empty rings", int'(inj_ready), (1 << N) - 1);
    drain(10);

    // R6: transit on clockwise ring blocks clockwise injection only
    clear_stage(); stg_v[0] = 1; stg_d[0] = 7; step();
    clear_stage(); stg_v[1] = 1; stg_d[1] = 3; stg_v[2] = 1; stg_d[2] = 0; step();
    chk(inj_ready[1] == 1'b0, "R6 clockwise injection waits behind transit", inj_ready[1], 0);
    chk(inj_ready[2] == 1'b1, "R6 counter-clockwise injection unaffected", inj_ready[2], 1);
    drain(10);

    // R7: local request blocked while the clockwise ring delivers there
    clear_stage(); stg_v[0] = 1; stg_d[0] = 1; step();
    clear_stage(); stg_v[1] = 1; stg_d[1] = 1; step();
    chk(inj_ready[1] == 1'b0, "R7 local waits for clockwise delivery", inj_ready[1], 0);
    step();
    chk(inj_ready[1] == 1'b1, "R7 local proceeds once lane free", inj_ready[1], 1);
    drain(4);

    // R10: one delivery from each ring at the same station in one cycle
    clear_stage(); stg_v[0] = 1; stg_d[0] = 1; stg_v[2] = 1; stg_d[2] = 1; step();
    clear_stage(); step(); step();
    chk(ej_cw_valid[1] && ej_ccw_valid[1], "R10 both lanes deliver together",
        int'({ej_cw_valid[1], ej_ccw_valid[1]}), 3);
    drain(4);

    // R4 / R2 tie: half-way goes clockwise, one past half goes counter-clockwise
    clear_stage(); stg_v[0] = 1; stg_d[0] = 7; step();
    clear_stage(); stg_v[0] = 1; stg_d[0] = 8; step();
    drain(10);

    // R5: local zero-hop delivery
    clear_stage(); stg_v[4] = 1; stg_d[4] = 4; step();
    chk(inj_ready[4] == 1'b1, "R5 local accepted on idle ring", inj_ready[4], 1);
    clear_stage(); step();
    chk(ej_cw_valid[4] == 1'b1, "R5 local delivered next cycle", ej_cw_valid[4], 1);
    drain(3);

    // R9: out-of-range destinations
    clear_stage(); stg_v[3] = 1; stg_d[3] = 14; stg_v[5] = 1; stg_d[5] = 15; step();
    chk(inj_ready[3] == 1'b0, "R9 destination 14 refused", inj_ready[3], 0);
    chk(inj_ready[5] == 1'b0, "R9 destination 15 refused", inj_ready[5], 0);
    drain(2);

    // Constrained random traffic on every station
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < N; i++) begin
        stg_v[i] = ($urandom % 100) < 30 && next_id < MAX_ID - 2 * N;
        stg_d[i] = $urandom % 16;
      end
      step();
      for (int i = 0; i < N; i++)
        if (stg_v[i] && stg_d[i] >= N)
          chk(inj_ready[i] == 1'b0, "R9 random out-of-range refused", inj_ready[i], 0);
    end
    drain(12);

    // R8: every accepted packet seen exactly once
    begin
      int bad = 0, n_acc = 0;
      for (int k = 0; k < next_id; k++)
        if (acc[k]) begin n_acc++; if (seen[k] != 1) bad++; end
      chk(bad == 0, "R8 packets not delivered exactly once", bad, 0);
      chk(n_acc > 200, "R8 accepted packet count", n_acc, 201);
    end
    chk(max_lat <= N/2, "R4 worst latency", max_lat, N/2);
    chk(max_lat == N/2, "R4 worst case reached", max_lat, N/2);
    finish_run();
  end
endmodule